// File: doc/BRIEF.md
# Multi-Port Register File with Selectable Write-Collision Policy

This block is a small register file that any number of write ports can update in the same clock cycle. Each write port carries a valid bit, an address and a data word. The block groups the requests by target address. When two or more valid ports aim at one address in one cycle, a policy chosen on a mode input decides what that address holds afterwards. The four policies are: all writers must agree, one writer picked by a rotating pointer, the lowest port index wins, or all values are combined with an associative operator (addition by default).

Read ports are purely combinational. Any number of them may look at the same word at once, and they need no arbitration. Writes are a stream with no back-pressure: the block has no ready signal, so every valid request is taken in the cycle it is presented. A write that breaks the agreement rule leaves its target word unchanged. It also sets a sticky error flag and records an address.

Top module: `cw_regfile`

## Requirements
- R1: After reset every word reads zero, the error flag is low, the reported error address is zero and the rotating pointer is zero.
- R2: A valid write is accepted in the cycle it is presented and is visible on the read ports only after the next rising clock edge. Before that edge, reads return the old value.
- R3: An address with exactly one valid writer in a cycle stores that writer's data unchanged, whatever the mode.
- R4: In agreement mode (code 0), colliding writers that all carry the same data store that data. If any of them differs, the word keeps its old value.
- R5: A disagreement in agreement mode raises the error flag. It stays high until reset. The error address holds the first offending address and does not change until reset; if several addresses disagree in the same cycle, the lowest one is taken.
- R6: In rank mode (code 2), the colliding writer with the lowest port index wins.
- R7: In rotating mode (code 1), a pointer that starts at zero after reset advances by one modulo the port count on every clock edge. The winner is the first valid colliding port found by scanning upward from the pointer, wrapping past the highest index.
- R8: In combine mode (code 3), the stored value is the sum of all colliding data words, taken modulo 2^DATA_W.
- R9: The mode code on the mode input is taken into the block only at a clock edge in a cycle with no valid write. While any write is valid, the policy in force stays the one latched earlier.
- R10: All read ports show the same word when they select the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 2 | Collision policy code: 0 agreement, 1 rotating, 2 rank, 3 combine |
| wr_valid | input | NUM_WR | Per-port write request |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port i in bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data, port i in bits [i*DATA_W +: DATA_W] |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, one field per read port |
| rd_data | output | NUM_RD*DATA_W | Read data, combinational from the stored words |
| err_flag | output | 1 | Sticky disagreement error |
| err_addr | output | ADDR_W | First address that saw a disagreement |

## Verification
Each mode is exercised with several kinds of write pattern:
- Every port writing a different address shows that lone writers always land.
- Full four-way collisions show what each policy does when all ports contend.
- Partial collisions, with only some ports valid, separate a rank winner from a rotating winner, and the rotating winner is predicted from the pointer position in that cycle.
- Colliding values that sum past the word width show the wrap in combine mode.
- Two collisions in one cycle show that the lower address is the one reported.

Finally, the mode input is changed during back-to-back write cycles; this shows that the latched policy, not the pin, decides the result.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    CW_AGREE  = 2'd0,
    CW_ROTATE = 2'd1,
    CW_RANK   = 2'd2,
    CW_MERGE  = 2'd3
  } cw_mode_e;
endpackage

// File: rtl/cw_rotor.sv
module cw_rotor #(
  parameter int NUM_WR = 4,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       ptr <= '0;
    else if (ptr == PW'(NUM_WR - 1))  ptr <= '0;
    else                              ptr <= ptr + PW'(1);
  end
endmodule

// File: rtl/cw_slot_resolve.sv
module cw_slot_resolve
  import cw_pkg::*;
#(
  parameter int NUM_WR = 4,
  parameter int DATA_W = 8,
  parameter int PW     = 2
) (
  input  logic [NUM_WR-1:0]        hit,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  cw_mode_e                 mode,
  input  logic [PW-1:0]            ptr,
  output logic                     commit,
  output logic [DATA_W-1:0]        value,
  output logic                     clash
);
  // Combining operator: swap the body for any associative operator.
  function automatic logic [DATA_W-1:0] merge_op(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic              seen;
  logic              agree;
  logic [DATA_W-1:0] first_v;
  logic [DATA_W-1:0] acc;
  logic              rot_found;
  logic [DATA_W-1:0] rot_v;

  always_comb begin
    seen    = 1'b0;
    agree   = 1'b1;
    first_v = '0;
    acc     = '0;
    for (int i = 0; i < NUM_WR; i++) begin
      if (hit[i]) begin
        if (!seen) begin
          first_v = wr_data[i*DATA_W +: DATA_W];
          acc     = wr_data[i*DATA_W +: DATA_W];
          seen    = 1'b1;
        end else begin
          acc = merge_op(acc, wr_data[i*DATA_W +: DATA_W]);
          if (wr_data[i*DATA_W +: DATA_W] != first_v) agree = 1'b0;
        end
      end
    end
  end

  always_comb begin
    rot_found = 1'b0;
    rot_v     = '0;
    for (int k = 0; k < NUM_WR; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_WR;
      if (!rot_found && hit[idx]) begin
        rot_found = 1'b1;
        rot_v     = wr_data[idx*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    commit = seen;
    value  = first_v;
    clash  = 1'b0;
    unique case (mode)
      CW_AGREE: begin
        commit = seen && agree;
        clash  = seen && !agree;
      end
      CW_ROTATE: value = rot_v;
      CW_RANK:   value = first_v;
      CW_MERGE:  value = acc;
      default:   value = first_v;
    endcase
  end
endmodule

// File: rtl/cw_err_track.sv
module cw_err_track #(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEPTH-1:0]  clash,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  logic [ADDR_W-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      if (clash[a]) lowest = ADDR_W'(a);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
    end else if (!err_flag && |clash) begin
      err_flag <= 1'b1;
      err_addr <= lowest;
    end
  end
endmodule

// File: rtl/cw_regfile.sv
module cw_regfile
  import cw_pkg::*;
#(
  parameter int NUM_WR = 4,
  parameter int NUM_RD = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_in,
  input  logic [NUM_WR-1:0]        wr_valid,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data,
  output logic                     err_flag,
  output logic [ADDR_W-1:0]        err_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

  cw_mode_e          mode_q;
  logic [PW-1:0]     ptr;
  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DEPTH-1:0]  commit;
  logic [DEPTH-1:0]  clash;
  logic [DATA_W-1:0] value  [DEPTH];

  // Policy is latched only in idle cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= CW_AGREE;
    else if (!(|wr_valid)) mode_q <= cw_mode_e'(mode_in);
  end

  cw_rotor #(.NUM_WR(NUM_WR), .PW(PW)) u_rotor (
    .clk(clk), .rst_n(rst_n), .ptr(ptr)
  );

  for (genvar a = 0; a < DEPTH; a++) begin : g_slot
    logic [NUM_WR-1:0] hit;
    always_comb begin
      for (int i = 0; i < NUM_WR; i++)
        hit[i] = wr_valid[i] && (wr_addr[i*ADDR_W +: ADDR_W] == ADDR_W'(a));
    end
    cw_slot_resolve #(.NUM_WR(NUM_WR), .DATA_W(DATA_W), .PW(PW)) u_res (
      .hit(hit), .wr_data(wr_data), .mode(mode_q), .ptr(ptr),
      .commit(commit[a]), .value(value[a]), .clash(clash[a])
    );
  end

  always_ff @(posedge clk) begin
    for (int a = 0; a < DEPTH; a++) begin
      if (!rst_n)         mem[a] <= '0;
      else if (commit[a]) mem[a] <= value[a];
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data[r*DATA_W +: DATA_W] = mem[rd_addr[r*ADDR_W +: ADDR_W]];
  end

  cw_err_track #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_err (
    .clk(clk), .rst_n(rst_n), .clash(clash),
    .err_flag(err_flag), .err_addr(err_addr)
  );
endmodule

// File: rtl/cw_regfile_chk.sv
module cw_regfile_chk #(
  parameter int NUM_WR = 4,
  parameter int ADDR_W = 3,
  parameter int PW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_WR-1:0] wr_valid,
  input logic [1:0]        mode_q,
  input logic [PW-1:0]     ptr,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr
);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(err_addr));

  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_valid) |=> $stable(mode_q));

  a_r7_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ptr == PW'((int'($past(ptr)) + 1) % NUM_WR)));
endmodule

bind cw_regfile cw_regfile_chk #(.NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .mode_q(mode_q),
  .ptr(ptr), .err_flag(err_flag), .err_addr(err_addr)
);

// File: tb/cw_regfile_tb_top.sv
`timescale 1ns/1ps
module cw_regfile_tb_top;
  localparam int P  = 4;
  localparam int R  = 2;
  localparam int AW = 3;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode_in = 2'd0;
  logic [P-1:0]    wr_valid = '0;
  logic [P*AW-1:0] wr_addr = '0;
  logic [P*DW-1:0] wr_data = '0;
  logic [R*AW-1:0] rd_addr = '0;
  logic [R*DW-1:0] rd_data;
  logic            err_flag;
  logic [AW-1:0]   err_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_busy = 1'b0;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] v;
    string         req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  cw_regfile #(.NUM_WR(P), .NUM_RD(R), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_flag(err_flag), .err_addr(err_addr)
  );

  // Pointer model: zero in reset, one step per edge otherwise (R7).
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
    item_t it;
    it.a = a; it.v = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  task automatic wr4(input logic [P-1:0] v,
                     input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                     input logic [AW-1:0] a2, input logic [AW-1:0] a3,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [DW-1:0] d2, input logic [DW-1:0] d3,
                     output int p_at);
    @(negedge clk);
    wr_valid = v;
    wr_addr  = {a3, a2, a1, a0};
    wr_data  = {d3, d2, d1, d0};
    p_at     = cyc % P;
    @(negedge clk);
    wr_valid = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    wr_valid = '0;
    mode_in  = m;
    @(negedge clk);
  endtask

  function automatic int pick(input logic [P-1:0] hits, input int p);
    for (int k = 0; k < P; k++) begin
      if (hits[(p + k) % P]) return (p + k) % P;
    end
    return 0;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor: scoreboard consumer, reads both ports at the same address.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        mon_busy = 1'b1;
        it = q.pop_front();
        rd_addr = {it.a, it.a};
        #1;
        chk(it.req, rd_data[DW-1:0], it.v);
        chk("R10 second port", rd_data[2*DW-1:DW], rd_data[DW-1:0]);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    int p;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 err_flag", err_flag, 0);
    chk("R1 err_addr", err_addr, 0);
    for (int a = 0; a < 8; a++) expect_word(AW'(a), 8'h00, "R1 word");
    drain();

    // R2: not visible until the edge
    @(negedge clk);
    wr_valid = 4'b0001; wr_addr = '0; wr_addr[AW-1:0] = 3'd1; wr_data = '0; wr_data[DW-1:0] = 8'h11;
    rd_addr = {3'd1, 3'd1};
    #1;
    chk("R2 before edge", rd_data[DW-1:0], 8'h00);
    @(posedge clk);
    #1;
    chk("R2 after edge", rd_data[DW-1:0], 8'h11);
    @(negedge clk);
    wr_valid = '0;

    // R3: lone writers in agreement mode
    wr4(4'b1111, 3'd2, 3'd3, 3'd4, 3'd5, 8'h22, 8'h33, 8'h44, 8'h55, p);
    expect_word(3'd2, 8'h22, "R3 lone p0");
    expect_word(3'd3, 8'h33, "R3 lone p1");
    expect_word(3'd4, 8'h44, "R3 lone p2");
    expect_word(3'd5, 8'h55, "R3 lone p3");
    drain();

    // R4: agreeing collision
    wr4(4'b0111, 3'd5, 3'd5, 3'd5, 3'd0, 8'h5A, 8'h5A, 8'h5A, 8'h00, p);
    expect_word(3'd5, 8'h5A, "R4 agree");
    drain();

    // R4/R5: two disagreeing addresses in one cycle
    wr4(4'b1111, 3'd6, 3'd6, 3'd4, 3'd4, 8'h10, 8'h20, 8'h01, 8'h02, p);
    chk("R5 flag set", err_flag, 1);
    chk("R5 lowest addr", err_addr, 3'd4);
    expect_word(3'd6, 8'h00, "R4 disagree keeps old");
    expect_word(3'd4, 8'h44, "R4 disagree keeps old");
    drain();

    // R5: later disagreement does not move the address
    wr4(4'b0011, 3'd1, 3'd1, 3'd0, 3'd0, 8'hAA, 8'hBB, 8'h00, 8'h00, p);
    chk("R5 flag sticky", err_flag, 1);
    chk("R5 addr held", err_addr, 3'd4);
    expect_word(3'd1, 8'h11, "R4 second disagree");
    drain();

    // R6: rank mode
    set_mode(2'd2);
    wr4(4'b1110, 3'd0, 3'd0, 3'd0, 3'd0, 8'h00, 8'h01, 8'h02, 8'h03, p);
    expect_word(3'd0, 8'h01, "R6 lowest valid port");
    drain();
    wr4(4'b1101, 3'd7, 3'd0, 3'd3, 3'd7, 8'h09, 8'h00, 8'hEE, 8'h08, p);
    expect_word(3'd7, 8'h09, "R6 port0 over port3");
    expect_word(3'd3, 8'hEE, "R3 lone in rank mode");
    drain();

    // R8: combine mode with wrap
    set_mode(2'd3);
    wr4(4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 8'h80, 8'h90, 8'h01, 8'h02, p);
    expect_word(3'd2, 8'h13, "R8 sum wraps");
    drain();
    wr4(4'b0010, 3'd0, 3'd5, 3'd0, 3'd0, 8'h00, 8'h21, 8'h00, 8'h00, p);
    expect_word(3'd5, 8'h21, "R3 lone in combine mode");
    drain();

    // R9: mode pin changes while writes are valid
    @(negedge clk);
    mode_in = 2'd2;
    wr_valid = 4'b0001; wr_addr = '0; wr_addr[AW-1:0] = 3'd6; wr_data = '0; wr_data[DW-1:0] = 8'h01;
    @(negedge clk);
    wr_valid = 4'b0011; wr_addr = {3'd0, 3'd0, 3'd6, 3'd6}; wr_data = {8'h00, 8'h00, 8'h20, 8'h10};
    @(negedge clk);
    wr_valid = '0;
    mode_in  = 2'd3;
    expect_word(3'd6, 8'h30, "R9 latched policy used");
    drain();

    // R7: rotating mode
    set_mode(2'd1);
    for (int n = 0; n < 3; n++) begin
      wr4(4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 8'hA0, 8'hA1, 8'hA2, 8'hA3, p);
      w = pick(4'b1111, p);
      expect_word(3'd4, 8'hA0 + DW'(w), "R7 full collision");
      drain();
    end
    for (int n = 0; n < 4; n++) begin
      wr4(4'b0101, 3'd1, 3'd0, 3'd1, 3'd0, 8'hC0, 8'h00, 8'hC2, 8'h00, p);
      w = pick(4'b0101, p);
      expect_word(3'd1, 8'hC0 + DW'(w), "R7 partial collision");
      drain();
    end

    report();
    $finish;
  end
endmodule